// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the converter side of a three-wire serial link: it turns a 14-bit parallel sample word into the bit stream that an analog-to-digital converter would put on its data line. An external master drives an active-low select and a serial clock. The block samples both on its own system clock and counts the falling serial-clock edges that arrive while it is selected. The data line is modelled as a data value plus a separate output-enable flag. The enable is low whenever the block is not selected.

After selection, the first four falling edges fall inside a sampling window and leave the line undriven. The fifth edge enables the line and drives a single low null bit. The word then follows most significant bit first, then two zero bits, then one more zero. After that the same word is sent again, least significant bit first. The line then stays low until select is released. The word is captured at the moment select falls, so a later change on the input does not disturb a frame in progress. The block can act as a bus-functional peer when testing a capture controller.

Top module: `adc_serial_seq`

## Requirements
- R1: While the synchronized select is high, sdo_oe_o and sdo_o are both 0, and serial-clock edges change neither of them nor the frame that the next selection produces.
- R2: After select falls, sdo_oe_o stays 0 through the first four counted falling serial-clock edges (SAMPLE_EDGES-1 with the default SAMPLE_EDGES of 5).
- R3: On the fifth counted falling edge, sdo_oe_o becomes 1 and sdo_o is 0 (the null bit).
- R4: On counted falling edges 6 to 19, sdo_o carries the captured word, bit 13 first and bit 0 last.
- R5: On counted falling edges 20 and 21, sdo_o is 0 (the two trailing zeros).
- R6: On counted falling edge 22, sdo_o is 0, and on edges 23 to 36 it carries the captured word again, bit 0 first and bit 13 last.
- R7: From counted edge 37 until select rises, sdo_oe_o stays 1 and sdo_o stays 0.
- R8: sample_i is captured on the clock cycle where the synchronized select falls; later changes of sample_i do not affect the frame.
- R9: sdo_o and sdo_oe_o change only in response to a detected falling serial-clock edge while selected, or to a change of select.
- R10: A frame restarts from its first edge only after select has gone high and then low again; raising select mid-frame abandons the frame.
- R11: cs_n_i and sclk_i each pass through SYNC_STAGES flip-flops (default 2). A level change sampled on rising clk edge k acts on the outputs at rising edge k+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; cs_n_i and sclk_i are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low select from the link master |
| sclk_i | input | 1 | Serial clock from the link master; bits change on its falling edge |
| sample_i | input | DATA_W | Parallel sample word, captured when select falls |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means the line is undriven |

## Verification
A slip in the internal edge count shows up as the null bit, the first data bit or the trailing zeros one edge early or late. A compare at every clock catches it within one serial-clock period of the slip. A stale or uncaptured word shows at the ports as wrong data bits from edge 6 on. A missed deselect leaves sdo_oe_o high SYNC_STAGES+1 cycles after select rises. A counter that fails to clear shifts the whole next frame, so its null bit appears before the fifth edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // Decoded position of the count after the current edge.
   typedef enum logic [2:0] {
      PH_SAMPLE,
      PH_NULL,
      PH_MSB,
      PH_TAIL,
      PH_LEAD,
      PH_LSB,
      PH_DONE
   } seq_phase_e;

   function automatic int idx_width(int data_w);
      return (data_w > 1) ? $clog2(data_w) : 1;
   endfunction

   // Count value at which the block has finished the reversed repeat.
   function automatic int done_count(int data_w, int sample_edges, int tail_zeros);
      return sample_edges + tail_zeros + 2 * data_w + 2;
   endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level_o,
   output logic fall_o
);

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level_o = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= {STAGES{RESET_VAL}};
            end else begin
               chain_q[0] <= din;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign level_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RESET_VAL;
      else        prev_q <= level_o;
   end

   assign fall_o = prev_q & ~level_o;

endmodule

// File: rtl/adc_seq_counter.sv
module adc_seq_counter
   import adc_seq_pkg::*;
#(
   parameter int DATA_W       = 14,
   parameter int SAMPLE_EDGES = 5,
   parameter int TAIL_ZEROS   = 2,
   parameter int IDX_W        = idx_width(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output seq_phase_e       phase_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o
);

   localparam int NULL_EDGE = SAMPLE_EDGES;
   localparam int MSB_FIRST = NULL_EDGE + 1;
   localparam int MSB_LAST  = NULL_EDGE + DATA_W;
   localparam int TAIL_LAST = MSB_LAST + TAIL_ZEROS;
   localparam int LEAD_EDGE = TAIL_LAST + 1;
   localparam int LSB_FIRST = LEAD_EDGE + 1;
   localparam int LSB_LAST  = LEAD_EDGE + DATA_W;
   localparam int DONE_CNT  = done_count(DATA_W, SAMPLE_EDGES, TAIL_ZEROS);
   localparam int CNT_W     = $clog2(DONE_CNT + 1);

   localparam logic [CNT_W-1:0] C_NULL      = CNT_W'(NULL_EDGE);
   localparam logic [CNT_W-1:0] C_MSB_FIRST = CNT_W'(MSB_FIRST);
   localparam logic [CNT_W-1:0] C_MSB_LAST  = CNT_W'(MSB_LAST);
   localparam logic [CNT_W-1:0] C_TAIL_LAST = CNT_W'(TAIL_LAST);
   localparam logic [CNT_W-1:0] C_LEAD      = CNT_W'(LEAD_EDGE);
   localparam logic [CNT_W-1:0] C_LSB_FIRST = CNT_W'(LSB_FIRST);
   localparam logic [CNT_W-1:0] C_LSB_LAST  = CNT_W'(LSB_LAST);
   localparam logic [CNT_W-1:0] C_DONE      = CNT_W'(DONE_CNT);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] msb_off;
   logic [CNT_W-1:0] lsb_off;

   always_comb begin
      cnt_nxt = cnt_q;
      if (clear_i) begin
         cnt_nxt = '0;
      end else if (step_i && (cnt_q != C_DONE)) begin
         cnt_nxt = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign msb_off = cnt_nxt - C_MSB_FIRST;
   assign lsb_off = cnt_nxt - C_LSB_FIRST;

   always_comb begin
      idx_o = '0;
      if (cnt_nxt < C_NULL) begin
         phase_o = PH_SAMPLE;
      end else if (cnt_nxt == C_NULL) begin
         phase_o = PH_NULL;
      end else if (cnt_nxt <= C_MSB_LAST) begin
         phase_o = PH_MSB;
         idx_o   = IDX_W'(DATA_W - 1) - IDX_W'(msb_off);
      end else if (cnt_nxt <= C_TAIL_LAST) begin
         phase_o = PH_TAIL;
      end else if (cnt_nxt == C_LEAD) begin
         phase_o = PH_LEAD;
      end else if (cnt_nxt <= C_LSB_LAST) begin
         phase_o = PH_LSB;
         idx_o   = IDX_W'(lsb_off);
      end else begin
         phase_o = PH_DONE;
      end
   end

   assign done_o = (cnt_q == C_DONE);

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
   import adc_seq_pkg::*;
#(
   parameter int DATA_W = 14,
   parameter int IDX_W  = idx_width(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              off_i,
   input  logic              step_i,
   input  seq_phase_e        phase_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              sdo_o,
   output logic              oe_o
);

   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (capture_i) word_q <= word_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo_o <= 1'b0;
         oe_o  <= 1'b0;
      end else if (off_i) begin
         sdo_o <= 1'b0;
         oe_o  <= 1'b0;
      end else if (step_i) begin
         unique case (phase_i)
            PH_SAMPLE: begin
               sdo_o <= 1'b0;
               oe_o  <= 1'b0;
            end
            PH_MSB, PH_LSB: begin
               sdo_o <= word_q[idx_i];
               oe_o  <= 1'b1;
            end
            default: begin
               sdo_o <= 1'b0;
               oe_o  <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
   import adc_seq_pkg::*;
#(
   parameter int   DATA_W       = 14,
   parameter int   SAMPLE_EDGES = 5,
   parameter int   TAIL_ZEROS   = 2,
   parameter int   SYNC_STAGES  = 2,
   parameter logic SCLK_IDLE    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o,
   output logic              sdo_oe_o
);

   localparam int IDX_W = idx_width(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("adc_serial_seq: DATA_W must be at least 2");
      end
      if (SAMPLE_EDGES < 1) begin : g_bad_sample
         $error("adc_serial_seq: SAMPLE_EDGES must be at least 1");
      end
      if (TAIL_ZEROS < 0) begin : g_bad_tail
         $error("adc_serial_seq: TAIL_ZEROS must not be negative");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("adc_serial_seq: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             cs_lvl;
   logic             cs_fall;
   logic             sclk_lvl;
   logic             sclk_fall;
   logic             clear;
   seq_phase_e       phase;
   logic [IDX_W-1:0] idx;
   logic             seq_done;

   adc_seq_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_cs_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (cs_n_i),
      .level_o (cs_lvl),
      .fall_o  (cs_fall)
   );

   adc_seq_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (SCLK_IDLE)
   ) u_sclk_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (sclk_i),
      .level_o (sclk_lvl),
      .fall_o  (sclk_fall)
   );

   // Deselect or a fresh selection both return the sequence to its start.
   assign clear = cs_lvl | cs_fall;

   adc_seq_counter #(
      .DATA_W       (DATA_W),
      .SAMPLE_EDGES (SAMPLE_EDGES),
      .TAIL_ZEROS   (TAIL_ZEROS),
      .IDX_W        (IDX_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .step_i  (sclk_fall),
      .phase_o (phase),
      .idx_o   (idx),
      .done_o  (seq_done)
   );

   adc_seq_shifter #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (cs_fall),
      .word_i    (sample_i),
      .off_i     (clear),
      .step_i    (sclk_fall),
      .phase_i   (phase),
      .idx_i     (idx),
      .sdo_o     (sdo_o),
      .oe_o      (sdo_oe_o)
   );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_lvl,
   input logic cs_fall,
   input logic sclk_lvl,
   input logic sclk_fall,
   input logic seq_done,
   input logic sdo,
   input logic oe
);

   // R1: deselection turns the enable off on the next cycle
   a_r1_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> !oe);

   // R1: the data value is low whenever the line is undriven
   a_r1_low_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !sdo);

   // R3: the enable rises with a low null bit, on a serial-clock fall
   a_r3_null_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> (!sdo && $past(sclk_fall) && !$past(sclk_lvl)));

   // R7: after the reversed repeat the line stays low
   a_r7_done_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !sdo);

   // R9: data moves only on a serial-clock fall or a select event
   a_r9_changes_on_events: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> ($past(sclk_fall) || $past(cs_lvl) || $past(cs_fall)));

   // R10: the enable is only ever high while selected
   a_r10_enable_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> !$past(cs_lvl));

endmodule

bind adc_serial_seq adc_seq_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_lvl    (cs_lvl),
   .cs_fall   (cs_fall),
   .sclk_lvl  (sclk_lvl),
   .sclk_fall (sclk_fall),
   .seq_done  (seq_done),
   .sdo       (sdo_o),
   .oe        (sdo_oe_o)
);

// File: tb/adc_serial_seq_tb_top.sv
module adc_serial_seq_tb_top;

   localparam int DW   = 14;
   localparam int SE   = 5;
   localparam int TZ   = 2;
   localparam int SS   = 2;
   localparam int HALF = 3;
   localparam int LAST = SE + TZ + 2 * DW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          sclk = 1'b0;
   logic [DW-1:0] sample = '0;
   logic          sdo;
   logic          sdo_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   adc_serial_seq #(
      .DATA_W       (DW),
      .SAMPLE_EDGES (SE),
      .TAIL_ZEROS   (TZ),
      .SYNC_STAGES  (SS)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_i   (cs_n),
      .sclk_i   (sclk),
      .sample_i (sample),
      .sdo_o    (sdo),
      .sdo_oe_o (sdo_oe)
   );

   // Reference model: inputs delayed by SS clocks (R11), frame as a bit queue.
   bit [1:0] hist[$];
   bit       frame_q[$];
   bit       m_pcs = 1'b1;
   bit       m_psclk = 1'b0;
   bit       m_sel = 1'b0;
   int       m_n = 0;
   bit       exp_sdo = 1'b0;
   bit       exp_oe = 1'b0;

   always @(posedge clk) begin : model
      bit [1:0] d;
      if (!rst_n) begin
         hist.delete();
         frame_q.delete();
         m_pcs = 1'b1; m_psclk = 1'b0; m_sel = 1'b0; m_n = 0;
         exp_sdo = 1'b0; exp_oe = 1'b0;
      end else begin
         hist.push_back({cs_n, sclk});
         if (hist.size() > SS) begin
            d = hist.pop_front();
            if (d[1]) begin
               exp_oe = 1'b0; exp_sdo = 1'b0; m_n = 0; m_sel = 1'b0;
               frame_q.delete();
            end else if (m_pcs) begin
               exp_oe = 1'b0; exp_sdo = 1'b0; m_n = 0; m_sel = 1'b1;
               frame_q.delete();
               frame_q.push_back(1'b0);
               for (int i = DW - 1; i >= 0; i--) frame_q.push_back(sample[i]);
               for (int i = 0; i < TZ; i++) frame_q.push_back(1'b0);
               frame_q.push_back(1'b0);
               for (int i = 0; i < DW; i++) frame_q.push_back(sample[i]);
            end else if (m_psclk && !d[0]) begin
               m_n++;
               if (m_n >= SE) begin
                  exp_oe  = 1'b1;
                  exp_sdo = (frame_q.size() > 0) ? frame_q.pop_front() : 1'b0;
               end
            end
            m_pcs   = d[1];
            m_psclk = d[0];
         end
      end
   end

   function automatic string req_of();
      if (!m_sel)             return "R1";
      if (m_n < SE)           return "R2";
      if (m_n == SE)          return "R3";
      if (m_n <= SE + DW)     return "R4 R8";
      if (m_n <= SE + DW + TZ) return "R5";
      if (m_n <= LAST)        return "R6 R8";
      return "R7";
   endfunction

   // Every-clock comparison; also covers R9 R10 R11 timing.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (sdo_oe !== exp_oe || sdo !== exp_sdo) begin
            fails++;
            $display("FAIL %s (R9 R10 R11) edge=%0d act oe=%b sdo=%b exp oe=%b sdo=%b",
                     req_of(), m_n, sdo_oe, sdo, exp_oe, exp_sdo);
         end
      end
   end

   task automatic chk(string req, logic act, logic expv, string what);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s act=%b exp=%b", req, what, act, expv);
      end
   endtask

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
   endtask

   task automatic frame(logic [DW-1:0] w, int nclk);
      sample = w;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (SS + 3) @(negedge clk);
      sample = ~w;   // R8: change after capture must not matter
      pulses(nclk);
      if (nclk > LAST) begin
         repeat (SS + 2) @(negedge clk);
         chk("R7", sdo_oe, 1'b1, "enable held after repeat");
         chk("R7", sdo, 1'b0, "data held low after repeat");
      end
      cs_n = 1'b1;
      repeat (SS + 2) @(negedge clk);
      chk("R1", sdo_oe, 1'b0, "enable after deselect");
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1", sdo_oe, 1'b0, "enable in reset");
      chk("R1", sdo, 1'b0, "data in reset");
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      // R1: clock activity while deselected
      pulses(8);
      chk("R1", sdo_oe, 1'b0, "enable with clocks while deselected");
      frame(14'h2A5C, 24);
      frame(14'h3FFF, 40);
      frame(14'h0000, 40);
      frame(14'h0001, 30);
      frame(14'h2000, 22);
      frame(14'h1555, 10);   // R10: abandoned mid-frame
      frame(14'h0ABC, 3);    // R2: abandoned in sampling window
      frame(14'h3C3C, 45);
      frame(14'h1234, 5);    // R3: ends right on the null bit
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule